// File: doc/BRIEF.md
# Per-Port Receive Statistics Counter Bank

The block keeps a set of receive statistics for each of a small number of ports. Every received packet is presented as a one-cycle event. The event carries the port, the frame length in bytes (CRC included), an interface-level receive error flag, an FCS error flag, a cast type and a parse mode. From one event the block updates, for that port, a clean-or-errored packet count, a total octet count, a length histogram, runt and oversize counts, and multicast or broadcast counts. A separate one-cycle drop event from the downstream admission logic adds to the port's dropped-packet and dropped-octet counts.

Software reads one counter at a time through a registered read port, which is addressed by port and counter select. A global clear-on-read input makes every read return the counter's value and then zero that counter. If an increment lands on the same counter in the same cycle, the counter restarts from that increment, so no event is lost. All counters saturate at the maximum value of their width.

Top module: `stats_bank`

## Requirements
- R1: After reset every counter of every port reads as zero, and `rdData` is zero until the first read completes.
- R2: A packet event with `evRxErr`=1 increments the 16-bit error count (select 1). With `evRxErr`=0 it increments the 32-bit clean packet count (select 0). It never increments both.
- R3: Every packet event adds `evLen`, which includes the 4-byte CRC, to the port's 64-bit total octet count (select 2).
- R4: The 32-bit histogram counts use selects 5 to 11, with bins of length exactly 64, 65..127, 128..255, 256..511, 512..1023, 1024..1518 and 1519..MAX_LEN. A frame shorter than 64 or longer than MAX_LEN falls in no bin.
- R5: A frame shorter than MIN_LEN increments select 12 when `evFcsErr`=0 and select 13 when `evFcsErr`=1. A frame longer than MAX_LEN increments select 14 when `evFcsErr`=0 and select 15 when `evFcsErr`=1.
- R6: Only when `evParse`=2'b01 (skip-to-L2), `evCast`=2'b01 increments the multicast count (select 3) and `evCast`=2'b10 increments the broadcast count (select 4). Any other cast or parse code increments neither count, and a broadcast never increments the multicast count.
- R7: A drop event adds 1 to the dropped-packet count (select 16) and `dropLen` to the 32-bit dropped-octet count (select 17) of `dropPort`.
- R8: A read with `rdEn`=1 returns, on `rdData` after the next clock edge, the counter at `rdPort`/`rdSel` as it stood before that edge. A select of 18 or more returns zero. `rdData` holds its value while `rdEn`=0.
- R9: With `clrOnRead`=1, a read zeroes the counter it reads. With `clrOnRead`=0, a read leaves the counter unchanged.
- R10: When a clearing read and an increment hit the same counter in the same cycle, the counter's new value is the increment amount.
- R11: Counters saturate at 2^W-1 for their width W (16 for select 1, 64 for select 2, 32 for all others) and never wrap.
- R12: Events and reads for one port do not change any other port's counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| evValid | input | 1 | Packet event strobe |
| evPort | input | PORT_W | Port of the packet event |
| evLen | input | LEN_W | Frame length in bytes including CRC |
| evRxErr | input | 1 | Interface-level receive error |
| evFcsErr | input | 1 | FCS error |
| evCast | input | 2 | 01 multicast, 10 broadcast, else unicast |
| evParse | input | 2 | Parse mode, 01 = skip-to-L2 |
| dropValid | input | 1 | Drop event strobe |
| dropPort | input | PORT_W | Port of the drop event |
| dropLen | input | LEN_W | Octets dropped |
| clrOnRead | input | 1 | Global read-clears-counter control |
| rdEn | input | 1 | Read strobe |
| rdPort | input | PORT_W | Port to read |
| rdSel | input | 5 | Counter select |
| rdData | output | 64 | Registered read data |

## Verification
The hardest state to reach from the ports is saturation. The 16-bit error count only reaches its ceiling after more than 65,535 errored packets, so the stimulus streams 65,540 back-to-back errored events into one port and then reads the count. The collision of a clearing read with an increment on the same counter must be lined up to the exact cycle, so directed steps issue both in one cycle and read the counter again afterwards. Around these, seeded random traffic mixes events, drops and reads with and without clearing, and each length boundary is driven on purpose.

// File: rtl/stats_pkg.sv
package stats_pkg;
  localparam int NCNT  = 18;
  localparam int SEL_W = 5;
  localparam int DW    = 64;

  // counter selects
  localparam int C_GOOD  = 0;
  localparam int C_ERR   = 1;
  localparam int C_OCTS  = 2;
  localparam int C_MCAST = 3;
  localparam int C_BCAST = 4;
  localparam int C_HIST0 = 5;
  localparam int NBIN    = 7;
  localparam int C_RUNT  = 12;
  localparam int C_RUNTF = 13;
  localparam int C_OVER  = 14;
  localparam int C_OVERF = 15;
  localparam int C_DPKT  = 16;
  localparam int C_DOCT  = 17;

  localparam logic [1:0] PARSE_L2 = 2'b01;
  localparam logic [1:0] CAST_MC  = 2'b01;
  localparam logic [1:0] CAST_BC  = 2'b10;

  typedef struct packed {
    logic [NCNT-1:0] pktBump;
    logic            dropBump;
    logic            rdClr;
  } ctlStrobes_t;

  function automatic int cntWidth(input int c);
    if (c == C_ERR)  return 16;
    if (c == C_OCTS) return 64;
    return 32;
  endfunction

  function automatic int binLo(input int i);
    if (i == 0) return 64;
    if (i == 1) return 65;
    if (i == 6) return 1519;
    return 1 << (i + 5);
  endfunction

  function automatic int binHi(input int i, input int maxLen);
    if (i == 0) return 64;
    if (i == 5) return 1518;
    if (i == 6) return maxLen;
    return (1 << (i + 6)) - 1;
  endfunction
endpackage

// File: rtl/stats_ctrl.sv
module stats_ctrl
  import stats_pkg::*;
#(
  parameter int LEN_W   = 14,
  parameter int MIN_LEN = 64,
  parameter int MAX_LEN = 9216
) (
  input  logic             evValid,
  input  logic [LEN_W-1:0] evLen,
  input  logic             evRxErr,
  input  logic             evFcsErr,
  input  logic [1:0]       evCast,
  input  logic [1:0]       evParse,
  input  logic             dropValid,
  input  logic             rdEn,
  input  logic             clrOnRead,
  output ctlStrobes_t      strb
);
  localparam logic [LEN_W-1:0] MINL = LEN_W'(MIN_LEN);
  localparam logic [LEN_W-1:0] MAXL = LEN_W'(MAX_LEN);

  logic isRunt, isOver, inL2;
  logic [NBIN-1:0] binHit;

  assign isRunt = evLen < MINL;
  assign isOver = evLen > MAXL;
  assign inL2   = evParse == PARSE_L2;

  for (genvar b = 0; b < NBIN; b++) begin : g_bin
    localparam logic [LEN_W-1:0] LO = LEN_W'(binLo(b));
    localparam logic [LEN_W-1:0] HI = LEN_W'(binHi(b, MAX_LEN));
    assign binHit[b] = (evLen >= LO) && (evLen <= HI);
  end

  always_comb begin
    strb = '0;
    if (evValid) begin
      strb.pktBump[C_GOOD]  = !evRxErr;
      strb.pktBump[C_ERR]   = evRxErr;
      strb.pktBump[C_OCTS]  = 1'b1;
      strb.pktBump[C_MCAST] = inL2 && (evCast == CAST_MC);
      strb.pktBump[C_BCAST] = inL2 && (evCast == CAST_BC);
      strb.pktBump[C_HIST0 +: NBIN] = binHit;
      strb.pktBump[C_RUNT]  = isRunt && !evFcsErr;
      strb.pktBump[C_RUNTF] = isRunt && evFcsErr;
      strb.pktBump[C_OVER]  = isOver && !evFcsErr;
      strb.pktBump[C_OVERF] = isOver && evFcsErr;
    end
    strb.dropBump = dropValid;
    strb.rdClr    = rdEn && clrOnRead;
  end
endmodule

// File: rtl/stats_datapath.sv
module stats_datapath
  import stats_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int PORT_W    = 2,
  parameter int LEN_W     = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strb,
  input  logic [PORT_W-1:0] evPort,
  input  logic [LEN_W-1:0]  evLen,
  input  logic [PORT_W-1:0] dropPort,
  input  logic [LEN_W-1:0]  dropLen,
  input  logic              rdEn,
  input  logic [PORT_W-1:0] rdPort,
  input  logic [SEL_W-1:0]  rdSel,
  output logic [DW-1:0]     rdData
);
  logic [DW-1:0] cnt [NUM_PORTS][NCNT];

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [PORT_W-1:0] PID = PORT_W'(p);
    for (genvar c = 0; c < NCNT; c++) begin : g_cnt
      localparam logic [DW-1:0]    MAXV = {DW{1'b1}} >> (DW - cntWidth(c));
      localparam logic [SEL_W-1:0] CID  = SEL_W'(c);
      localparam bit IS_DROP = (c == C_DPKT) || (c == C_DOCT);
      logic          hit, clrHit;
      logic [DW-1:0] amount, base;
      logic [DW:0]   sum;

      if (IS_DROP) begin : g_drop
        assign hit = strb.dropBump && (dropPort == PID);
      end else begin : g_pkt
        assign hit = strb.pktBump[c] && (evPort == PID);
      end

      if (c == C_OCTS) begin : g_amtEv
        assign amount = DW'(evLen);
      end else if (c == C_DOCT) begin : g_amtDrop
        assign amount = DW'(dropLen);
      end else begin : g_amtOne
        assign amount = DW'(1);
      end

      assign clrHit = strb.rdClr && (rdPort == PID) && (rdSel == CID);
      assign base   = clrHit ? '0 : cnt[p][c];
      assign sum    = {1'b0, base} + {1'b0, (hit ? amount : '0)};

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          cnt[p][c] <= '0;
        else if (sum > {1'b0, MAXV})
          cnt[p][c] <= MAXV;
        else
          cnt[p][c] <= sum[DW-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      rdData <= '0;
    else if (rdEn) begin
      if (rdSel < SEL_W'(NCNT) && int'(rdPort) < NUM_PORTS)
        rdData <= cnt[rdPort][rdSel];
      else
        rdData <= '0;
    end
  end
endmodule

// File: rtl/stats_bank.sv
module stats_bank
  import stats_pkg::*;
#(
  parameter int NUM_PORTS = 4,
  parameter int LEN_W     = 14,
  parameter int MIN_LEN   = 64,
  parameter int MAX_LEN   = 9216,
  localparam int PORT_W   = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              evValid,
  input  logic [PORT_W-1:0] evPort,
  input  logic [LEN_W-1:0]  evLen,
  input  logic              evRxErr,
  input  logic              evFcsErr,
  input  logic [1:0]        evCast,
  input  logic [1:0]        evParse,
  input  logic              dropValid,
  input  logic [PORT_W-1:0] dropPort,
  input  logic [LEN_W-1:0]  dropLen,
  input  logic              clrOnRead,
  input  logic              rdEn,
  input  logic [PORT_W-1:0] rdPort,
  input  logic [4:0]        rdSel,
  output logic [63:0]       rdData
);
  ctlStrobes_t strb;

  stats_ctrl #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .MAX_LEN(MAX_LEN)) u_ctrl (
    .evValid(evValid), .evLen(evLen), .evRxErr(evRxErr), .evFcsErr(evFcsErr),
    .evCast(evCast), .evParse(evParse), .dropValid(dropValid),
    .rdEn(rdEn), .clrOnRead(clrOnRead), .strb(strb)
  );

  stats_datapath #(.NUM_PORTS(NUM_PORTS), .PORT_W(PORT_W), .LEN_W(LEN_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .evPort(evPort), .evLen(evLen), .dropPort(dropPort), .dropLen(dropLen),
    .rdEn(rdEn), .rdPort(rdPort), .rdSel(rdSel), .rdData(rdData)
  );
endmodule

// File: rtl/stats_bank_chk.sv
module stats_bank_chk #(
  parameter int PORT_W = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              evValid,
  input logic              dropValid,
  input logic              clrOnRead,
  input logic              rdEn,
  input logic [PORT_W-1:0] rdPort,
  input logic [4:0]        rdSel,
  input logic [63:0]       rdData
);
  // R8: read data holds between reads
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    !rdEn |=> $stable(rdData));

  // R8: unused selects read as zero
  a_r8_bad_sel_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdSel >= 5'd18) |=> rdData == 64'd0);

  // R9: a clearing read with no traffic leaves zero for the next read
  a_r9_clear_sticks: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && clrOnRead && !evValid && !dropValid) ##1
    (rdEn && rdPort == $past(rdPort) && rdSel == $past(rdSel))
    |=> rdData == 64'd0);

  // R11: without clearing, back-to-back reads of one counter never go down
  a_r11_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !clrOnRead) ##1
    (rdEn && !clrOnRead && rdPort == $past(rdPort) && rdSel == $past(rdSel))
    |=> rdData >= $past(rdData));

  // R11: error count never exceeds 16 bits
  a_r11_err_width: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdSel == 5'd1) |=> rdData[63:16] == 48'd0);

  // R11: all counters other than the octet total stay within 32 bits
  a_r11_word_width: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && rdSel != 5'd2) |=> rdData[63:32] == 32'd0);
endmodule

bind stats_bank stats_bank_chk #(.PORT_W(PORT_W)) u_chk (
  .clk(clk), .rstN(rstN), .evValid(evValid), .dropValid(dropValid),
  .clrOnRead(clrOnRead), .rdEn(rdEn), .rdPort(rdPort), .rdSel(rdSel),
  .rdData(rdData)
);

// File: tb/tb_stats_bank.sv
module tb_stats_bank;
  localparam int NP = 4;
  localparam int NC = 18;
  localparam int MAXL = 9216;

  logic clk = 0, rstN = 0;
  logic evValid = 0, evRxErr = 0, evFcsErr = 0, dropValid = 0, clrOnRead = 0, rdEn = 0;
  logic [1:0] evPort = 0, dropPort = 0, rdPort = 0, evCast = 0, evParse = 0;
  logic [13:0] evLen = 0, dropLen = 0;
  logic [4:0] rdSel = 0;
  logic [63:0] rdData;

  always #5 clk = ~clk;

  stats_bank dut (.*);

  longint unsigned exp [NP][NC];
  int nChk = 0, nBad = 0;
  string curTag = "";

  function automatic longint unsigned capOf(int s);
    if (s == 1) return 64'hFFFF;
    if (s == 2) return 64'hFFFF_FFFF_FFFF_FFFF;
    return 64'hFFFF_FFFF;
  endfunction

  function automatic string tagOf(int s);
    if (curTag != "") return curTag;
    if (s <= 1) return "R2";
    if (s == 2) return "R3";
    if (s <= 4) return "R6";
    if (s <= 11) return "R4";
    if (s <= 15) return "R5";
    if (s <= 17) return "R7";
    return "R8";
  endfunction

  function automatic int binOf(int len);
    if (len == 64) return 5;
    if (len >= 65 && len <= 127) return 6;
    if (len >= 128 && len <= 255) return 7;
    if (len >= 256 && len <= 511) return 8;
    if (len >= 512 && len <= 1023) return 9;
    if (len >= 1024 && len <= 1518) return 10;
    if (len >= 1519 && len <= MAXL) return 11;
    return -1;
  endfunction

  task automatic add(int p, int s, longint unsigned amt);
    longint unsigned v = exp[p][s] + amt;
    exp[p][s] = (v > capOf(s)) ? capOf(s) : v;
  endtask

  task automatic check(string tag, int p, int s, longint unsigned got, longint unsigned want);
    nChk++;
    if (got !== want) begin
      nBad++;
      $display("FAIL %s port %0d sel %0d: got %0d expected %0d", tag, p, s, got, want);
    end
  endtask

  task automatic idle();
    evValid = 0; dropValid = 0; rdEn = 0;
  endtask

  // one clock of stimulus, model update, then check of the read issued
  task automatic tick();
    bit rd = rdEn;
    int p = int'(rdPort), s = int'(rdSel);
    longint unsigned want = (s < NC) ? exp[p][s] : 0;
    if (rdEn && clrOnRead && s < NC) exp[p][s] = 0;
    if (evValid) begin
      int ep = int'(evPort), L = int'(evLen);
      if (evRxErr) add(ep, 1, 1); else add(ep, 0, 1);
      add(ep, 2, L);
      if (evParse == 2'b01 && evCast == 2'b01) add(ep, 3, 1);
      if (evParse == 2'b01 && evCast == 2'b10) add(ep, 4, 1);
      if (binOf(L) >= 0) add(ep, binOf(L), 1);
      if (L < 64) add(ep, evFcsErr ? 13 : 12, 1);
      if (L > MAXL) add(ep, evFcsErr ? 15 : 14, 1);
    end
    if (dropValid) begin
      add(int'(dropPort), 16, 1);
      add(int'(dropPort), 17, dropLen);
    end
    @(negedge clk);
    if (rd) check(tagOf(s), p, s, rdData, want);
  endtask

  task automatic readOne(int p, int s, bit clr);
    idle(); clrOnRead = clr; rdEn = 1; rdPort = 2'(p); rdSel = 5'(s);
    tick(); idle();
  endtask

  task automatic sendPkt(int p, int len, bit rxe, bit fcs, int cast, int parse);
    idle(); evValid = 1; evPort = 2'(p); evLen = 14'(len); evRxErr = rxe;
    evFcsErr = fcs; evCast = 2'(cast); evParse = 2'(parse);
    tick(); idle();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    int corners [15] = '{63, 64, 65, 127, 128, 255, 256, 511, 512, 1023, 1024, 1518, 1519, MAXL, MAXL + 1};
    void'($urandom(32'd2024));
    for (int p = 0; p < NP; p++) for (int s = 0; s < NC; s++) exp[p][s] = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1: reset state
    curTag = "R1";
    check("R1", 0, 0, rdData, 0);
    for (int s = 0; s < NC; s++) readOne(1, s, 0);

    // R4 / R5 / R3 boundary lengths on port 0
    curTag = "";
    foreach (corners[i]) sendPkt(0, corners[i], 0, 0, 0, 0);
    sendPkt(0, 40, 0, 1, 0, 0);
    sendPkt(0, MAXL + 5, 0, 1, 0, 0);
    for (int s = 2; s <= 15; s++) readOne(0, s, 0);

    // R6: cast only in skip-to-L2 mode, broadcast not multicast
    sendPkt(3, 100, 0, 0, 2, 1);
    sendPkt(3, 100, 0, 0, 1, 1);
    sendPkt(3, 100, 0, 0, 1, 0);
    sendPkt(3, 100, 0, 0, 2, 2);
    readOne(3, 3, 0);
    readOne(3, 4, 0);

    // R9: read-clear versus plain read
    curTag = "R9";
    readOne(0, 2, 0);
    readOne(0, 2, 0);
    readOne(0, 2, 1);
    readOne(0, 2, 0);

    // R10: clearing read and increment on same counter in one cycle
    curTag = "R10";
    sendPkt(1, 80, 0, 0, 0, 0);
    sendPkt(1, 80, 0, 0, 0, 0);
    idle(); evValid = 1; evPort = 1; evLen = 80; evRxErr = 0; evFcsErr = 0;
    clrOnRead = 1; rdEn = 1; rdPort = 1; rdSel = 0;
    tick(); idle();
    readOne(1, 0, 0);

    // R12: traffic on port 2 leaves port 1 alone
    curTag = "R12";
    sendPkt(2, 300, 0, 0, 0, 0);
    readOne(1, 0, 0);
    readOne(1, 8, 0);

    // random mix
    curTag = "";
    for (int n = 0; n < 3000; n++) begin
      idle();
      evValid = ($urandom_range(9) < 7);
      evPort = 2'($urandom_range(3));
      evLen = ($urandom_range(1) == 1) ? 14'(corners[$urandom_range(14)]) : 14'($urandom_range(10000, 20));
      evRxErr = ($urandom_range(9) == 0);
      evFcsErr = ($urandom_range(9) < 2);
      evCast = 2'($urandom_range(3));
      evParse = 2'($urandom_range(3));
      dropValid = ($urandom_range(9) < 3);
      dropPort = 2'($urandom_range(3));
      dropLen = 14'($urandom_range(9000, 1));
      rdEn = ($urandom_range(9) < 4);
      rdPort = 2'($urandom_range(3));
      rdSel = 5'($urandom_range(19));
      if ($urandom_range(19) == 0) clrOnRead = ~clrOnRead;
      tick();
    end
    idle();
    for (int p = 0; p < NP; p++) for (int s = 0; s < NC + 2; s++) readOne(p, s, 0);

    // R11: saturation of the 16-bit error count
    curTag = "R11";
    idle(); evValid = 1; evPort = 2; evLen = 64; evRxErr = 1; evFcsErr = 0;
    evCast = 0; evParse = 0;
    repeat (65540) tick();
    idle();
    readOne(2, 1, 0);
    check("R11", 2, 1, rdData, 64'hFFFF);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule